// File: doc/BRIEF.md
# Multi-Mode 16-bit Waveform Timer

A 16-bit counter whose behaviour comes from a 4-bit mode register. Each of the 16 modes sets four things: whether the counter counts up and wraps, or counts up and then back down; where the turn-around value TOP comes from; when the compare value written by the host takes effect; and which counter event sets the overflow flag. The mode group picks how the single PWM output is driven. The modes cover free running, clear-on-compare, single-slope PWM, dual-slope PWM, and dual-slope PWM with its compare update at the bottom.

The host uses write strobes to load the mode, the compare value and the capture value. It clears the overflow flag with a one-cycle pulse. Compare writes always land in a shadow register. The mode decides when the shadow moves into the active compare value that drives the output and, in some modes, TOP. The count enable lets an external prescaler pace the counter.

Top module: `wave_timer`

## Requirements
- R1: After the asynchronous reset, cnt_o, cmpa_o, pwm_o and ovf_o are all zero, the mode is 0, and the capture value is zero.
- R2: While cnt_en_i is low, the counter, the overflow flag, the PWM output and any pending compare update at TOP or BOTTOM stay unchanged.
- R3: In modes 0, 4, 5, 6, 7, 12, 14 and 15 the counter advances by one per enabled cycle. On the enabled cycle where it equals TOP, it returns to 0.
- R4: In modes 1, 2, 3, 8, 9, 10 and 11 the counter counts 0, 1, …, TOP, then TOP-1 down to 0, then 1 upward again. After the first pass the period is 2·TOP cycles.
- R5: The TOP source depends on the mode. Mode 0 uses 0xFFFF. Modes 1/5 use 0x00FF, modes 2/6 use 0x01FF and modes 3/7 use 0x03FF. Modes 4, 9, 11 and 15 use the active compare value. Modes 8, 10, 12 and 14 use the capture value, which is loaded by cap_we_i.
- R6: In modes 0, 4 and 12 a compare write is visible on cmpa_o in the next cycle.
- R7: In modes 1, 2, 3, 10 and 11 the shadowed compare value moves to cmpa_o on the enabled step out of the state where the counter is at TOP counting up. At no other time does cmpa_o change.
- R8: In modes 5, 6, 7, 14 and 15 the shadow moves to cmpa_o when the counter wraps from TOP to 0. In modes 8 and 9 it moves on the enabled step out of 0 while counting down. A compare write in that same cycle goes straight to cmpa_o.
- R9: The overflow flag is set in three places. In modes 0, 4 and 12 it is set on the wrap from 0xFFFF. In the single-slope PWM modes it is set on the wrap from TOP. In the dual-slope modes it is set on the step out of 0 while counting down. In each case it is visible in the cycle after the event.
- R10: The overflow flag stays set until ovf_clr_i is high at a clock edge. If a set event and a clear fall on the same edge, the flag stays set.
- R11: In modes 5, 6, 7, 14 and 15, pwm_o goes to 1 on the wrap from TOP to 0. It goes to 0 on the step out of the count value equal to cmpa_o. A match at TOP keeps it 1.
- R12: In the dual-slope modes, pwm_o goes to 0 on a compare match while counting up and to 1 on a compare match while counting down. In the other non-PWM modes it holds.
- R13: Mode 13 is reserved. In it the counter holds and the overflow flag is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable (one counter step per high cycle) |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_i | input | 4 | Mode value |
| cmpa_we_i | input | 1 | Compare write strobe (shadow register) |
| cmpa_i | input | 16 | Compare write data |
| cap_we_i | input | 1 | Capture register write strobe |
| cap_i | input | 16 | Capture write data |
| ovf_clr_i | input | 1 | Overflow flag clear pulse |
| cnt_o | output | 16 | Counter value |
| cmpa_o | output | 16 | Active compare value |
| pwm_o | output | 1 | PWM output |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Two events can land on the same clock edge: the overflow set event, which comes from the counter reaching the mode's flag point, and a host clear pulse. The bench places ovf_clr_i on the exact cycle the single-slope counter sits at TOP. The flag must still read one in the next cycle, and a second clear one cycle later must drop it. The bench also places a compare write on the cycle of the compare update event and expects the freshly written value on cmpa_o right away.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [1:0] {TS_MAX, TS_FIX, TS_CMP, TS_CAP} top_src_e;
  typedef enum logic [1:0] {EV_NOW, EV_TOP, EV_BOT, EV_MAX} ev_e;
  typedef enum logic [1:0] {PW_OFF, PW_FAST, PW_DUAL} pwm_e;

  typedef struct packed {
    top_src_e   top_src;
    logic [1:0] fix_sel;
    logic       dual;
    ev_e        upd;
    ev_e        flg;
    pwm_e       pwm;
    logic       hold;
  } mode_cfg_t;
endpackage

// File: rtl/wt_mode_lut.sv
module wt_mode_lut
  import wt_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output mode_cfg_t         cfg_o
);
  always_comb begin
    cfg_o.top_src = TS_MAX;
    cfg_o.fix_sel = mode_i[1:0] - 2'd1;
    cfg_o.dual    = 1'b0;
    cfg_o.upd     = EV_NOW;
    cfg_o.flg     = EV_MAX;
    cfg_o.pwm     = PW_OFF;
    cfg_o.hold    = 1'b0;
    case (mode_i)
      4'd0: ;
      4'd1, 4'd2, 4'd3: begin
        cfg_o.top_src = TS_FIX; cfg_o.dual = 1'b1;
        cfg_o.upd = EV_TOP; cfg_o.flg = EV_BOT; cfg_o.pwm = PW_DUAL;
      end
      4'd4: cfg_o.top_src = TS_CMP;
      4'd5, 4'd6, 4'd7: begin
        cfg_o.top_src = TS_FIX;
        cfg_o.upd = EV_BOT; cfg_o.flg = EV_TOP; cfg_o.pwm = PW_FAST;
      end
      4'd8, 4'd9: begin
        cfg_o.top_src = mode_i[0] ? TS_CMP : TS_CAP; cfg_o.dual = 1'b1;
        cfg_o.upd = EV_BOT; cfg_o.flg = EV_BOT; cfg_o.pwm = PW_DUAL;
      end
      4'd10, 4'd11: begin
        cfg_o.top_src = mode_i[0] ? TS_CMP : TS_CAP; cfg_o.dual = 1'b1;
        cfg_o.upd = EV_TOP; cfg_o.flg = EV_BOT; cfg_o.pwm = PW_DUAL;
      end
      4'd12: cfg_o.top_src = TS_CAP;
      4'd13: cfg_o.hold = 1'b1;
      default: begin
        cfg_o.top_src = mode_i[0] ? TS_CMP : TS_CAP;
        cfg_o.upd = EV_BOT; cfg_o.flg = EV_TOP; cfg_o.pwm = PW_FAST;
      end
    endcase
  end
endmodule

// File: rtl/wt_top_sel.sv
module wt_top_sel
  import wt_pkg::*;
#(
  parameter int W        = 16,
  parameter int FIX_BASE = 8,
  parameter int FIX_N    = 3
) (
  input  top_src_e     src_i,
  input  logic [1:0]   fix_sel_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] cap_i,
  output logic [W-1:0] top_o
);
  logic [W-1:0] fix_tab [FIX_N];

  for (genvar g = 0; g < FIX_N; g++) begin : g_fix
    assign fix_tab[g] = W'((64'd1 << (FIX_BASE + g)) - 64'd1);
  end

  logic [W-1:0] fix_val;
  always_comb begin
    fix_val = '1;
    for (int k = 0; k < FIX_N; k++)
      if (int'(fix_sel_i) == k) fix_val = fix_tab[k];
  end

  always_comb begin
    case (src_i)
      TS_FIX:  top_o = fix_val;
      TS_CMP:  top_o = cmp_i;
      TS_CAP:  top_o = cap_i;
      default: top_o = '1;
    endcase
  end
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         hold_i,
  input  logic         dual_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         up_o
);
  logic [W-1:0] cnt_q;
  logic         up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (en_i && !hold_i) begin
      if (!dual_i) begin
        up_q  <= 1'b1;
        cnt_q <= (cnt_q == top_i) ? '0 : cnt_q + 1'b1;
      end else if (up_q) begin
        if (cnt_q >= top_i) begin
          up_q  <= 1'b0;
          cnt_q <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cnt_q == '0) begin
        up_q  <= 1'b1;
        cnt_q <= W'(1);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q) && $stable(up_q));
  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !hold_i && !dual_i && cnt_q == top_i |=> cnt_q == '0);
  assert_turn_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !hold_i && dual_i && up_q && cnt_q == top_i && top_i != '0 |=> !up_q);
endmodule

// File: rtl/wt_pwm.sv
module wt_pwm
  import wt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  pwm_e         kind_i,
  input  logic [W-1:0] cnt_i,
  input  logic         up_i,
  input  logic [W-1:0] top_i,
  input  logic [W-1:0] cmp_i,
  output logic         pwm_o
);
  logic pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
    end else if (step_i) begin
      case (kind_i)
        PW_FAST: begin
          if (cnt_i == top_i)      pwm_q <= 1'b1;
          else if (cnt_i == cmp_i) pwm_q <= 1'b0;
        end
        PW_DUAL: if (cnt_i == cmp_i) pwm_q <= ~up_i;
        default: ;
      endcase
    end
  end

  assign pwm_o = pwm_q;

  assert_fast_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && kind_i == PW_FAST && cnt_i == top_i |=> pwm_q);
  assert_dual_clr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && kind_i == PW_DUAL && cnt_i == cmp_i && up_i |=> !pwm_q);
  assert_off_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == PW_OFF |=> $stable(pwm_q));
endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wt_pkg::*;
#(
  parameter int W        = 16,
  parameter int FIX_BASE = 8,
  parameter int FIX_N    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              cmpa_we_i,
  input  logic [W-1:0]      cmpa_i,
  input  logic              cap_we_i,
  input  logic [W-1:0]      cap_i,
  input  logic              ovf_clr_i,
  output logic [W-1:0]      cnt_o,
  output logic [W-1:0]      cmpa_o,
  output logic              pwm_o,
  output logic              ovf_o
);
  logic [MODE_W-1:0] mode_q;
  logic [W-1:0]      shadow_q, cmp_q, cap_q, top, cnt;
  logic              ovf_q, up, step, hit_top, hit_bot, hit_max, upd_ev, flg_ev;
  mode_cfg_t         cfg;

  wt_mode_lut u_lut (.mode_i(mode_q), .cfg_o(cfg));

  wt_top_sel #(.W(W), .FIX_BASE(FIX_BASE), .FIX_N(FIX_N)) u_top (
    .src_i(cfg.top_src), .fix_sel_i(cfg.fix_sel),
    .cmp_i(cmp_q), .cap_i(cap_q), .top_o(top)
  );

  wt_counter #(.W(W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cnt_en_i), .hold_i(cfg.hold),
    .dual_i(cfg.dual), .top_i(top), .cnt_o(cnt), .up_o(up)
  );

  assign step    = cnt_en_i & ~cfg.hold;
  assign hit_top = step & (cnt == top) & (~cfg.dual | up);
  assign hit_bot = step & cfg.dual & ~up & (cnt == '0);
  assign hit_max = step & ~cfg.dual & (cnt == '1);

  always_comb begin
    case (cfg.upd)
      EV_NOW:  upd_ev = cmpa_we_i;
      EV_TOP:  upd_ev = hit_top;
      EV_BOT:  upd_ev = cfg.dual ? hit_bot : hit_top;
      default: upd_ev = 1'b0;
    endcase
    case (cfg.flg)
      EV_MAX:  flg_ev = hit_max;
      EV_TOP:  flg_ev = hit_top;
      EV_BOT:  flg_ev = hit_bot;
      default: flg_ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      shadow_q <= '0;
      cmp_q    <= '0;
      cap_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (mode_we_i) mode_q <= mode_i;
      if (cap_we_i)  cap_q  <= cap_i;
      if (cmpa_we_i) shadow_q <= cmpa_i;
      // a write landing on the update point goes straight through
      if (upd_ev)    cmp_q <= cmpa_we_i ? cmpa_i : shadow_q;
      // set wins over clear
      if (flg_ev)         ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  wt_pwm #(.W(W)) u_pwm (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .kind_i(cfg.pwm),
    .cnt_i(cnt), .up_i(up), .top_i(top), .cmp_i(cmp_q), .pwm_o(pwm_o)
  );

  assign cnt_o  = cnt;
  assign cmpa_o = cmp_q;
  assign ovf_o  = ovf_q;

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !ovf_clr_i |=> ovf_q);
  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flg_ev |=> ovf_q);
  assert_cmp_still_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_ev |=> $stable(cmp_q));
  assert_rsv_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.hold && !mode_we_i |=> $stable(cnt) && !$rose(ovf_q));
endmodule

// File: tb/sim_wave_timer.sv
`timescale 1ns/1ps
module sim_wave_timer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_en_i = 1'b0, mode_we_i = 1'b0, cmpa_we_i = 1'b0, cap_we_i = 1'b0, ovf_clr_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [15:0] cmpa_i = '0, cap_i = '0;
  logic [15:0] cnt_o, cmpa_o;
  logic        pwm_o, ovf_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wave_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i), .mode_we_i(mode_we_i), .mode_i(mode_i),
    .cmpa_we_i(cmpa_we_i), .cmpa_i(cmpa_i), .cap_we_i(cap_we_i), .cap_i(cap_i),
    .ovf_clr_i(ovf_clr_i), .cnt_o(cnt_o), .cmpa_o(cmpa_o), .pwm_o(pwm_o), .ovf_o(ovf_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic adv(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; cnt_en_i = 0; mode_we_i = 0; cmpa_we_i = 0; cap_we_i = 0; ovf_clr_i = 0;
    adv(2);
    rst_ni = 1'b1;
  endtask

  // leaves the bench at step n=0 with counting enabled
  task automatic setup(int mode, int cmp, int cap);
    do_reset();
    cmpa_we_i = 1; cmpa_i = 16'(cmp);
    adv(1);
    cmpa_we_i = 0; cap_we_i = 1; cap_i = 16'(cap);
    adv(1);
    cap_we_i = 0; mode_we_i = 1; mode_i = 4'(mode);
    adv(1);
    mode_we_i = 0; cnt_en_i = 1;
  endtask

  // kind: 0 clear-on-compare, 1 single-slope PWM, 2 dual-slope PWM
  task automatic run_sweep(int mode, int cmp, int cap, int top, int kind, int steps);
    setup(mode, cmp, cap);
    for (int n = 0; n <= steps; n++) begin
      int c, p;
      bit up;
      if (kind == 2) begin
        p  = n % (2 * top);
        c  = (p <= top) ? p : 2 * top - p;
        up = (p >= 1 && p <= top);
        chk("R4 R5 count", cnt_o, c);
        chk("R9 flag", ovf_o, (n >= 2 * top + 1));
        if (n >= 2 * top + 1 && cmp >= 1 && cmp < top)
          chk("R12 pwm", pwm_o, up ? (c <= cmp) : (c < cmp));
      end else begin
        c = n % (top + 1);
        chk("R3 R5 count", cnt_o, c);
        chk("R9 flag", ovf_o, (kind == 1) ? (n >= top + 1) : 0);
        if (kind == 1 && n >= top + 1 && cmp >= 1 && cmp < top)
          chk("R11 pwm", pwm_o, (c <= cmp));
      end
      chk("R7 R8 cmp steady", cmpa_o, cmp);
      adv(1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int tops[4];
    tops = '{2, 3, 5, 9};
    adv(2);
    chk("R1 cnt", cnt_o, 0); chk("R1 cmp", cmpa_o, 0);
    chk("R1 pwm", pwm_o, 0); chk("R1 ovf", ovf_o, 0);

    // fixed-TOP modes
    for (int m = 1; m <= 3; m++) begin
      int t;
      t = (1 << (7 + m)) - 1;
      run_sweep(m, t / 3, 0, t, 2, 4 * t + 2);
    end
    for (int m = 5; m <= 7; m++) begin
      int t;
      t = (1 << (3 + m)) - 1;
      run_sweep(m, t / 3, 0, t, 1, 2 * (t + 1) + 3);
    end

    // register-TOP modes, swept over small tops and compare values
    for (int i = 0; i < 4; i++) begin
      int t;
      t = tops[i];
      run_sweep(9,  t, 0, t, 2, 4 * t + 3);
      run_sweep(11, t, 0, t, 2, 4 * t + 3);
      run_sweep(15, t, 0, t, 1, 3 * t + 4);
      run_sweep(4,  t, 0, t, 0, 3 * t + 4);
      run_sweep(12, 1, t, t, 0, 3 * t + 4);
      for (int o = 1; o < t; o++) begin
        run_sweep(8,  o, t, t, 2, 4 * t + 3);
        run_sweep(10, o, t, t, 2, 4 * t + 3);
        run_sweep(14, o, t, t, 1, 3 * t + 4);
      end
    end

    // R8 single-slope update at wrap, plus write on the update cycle
    setup(14, 2, 7);
    adv(4); cmpa_we_i = 1; cmpa_i = 16'd5;
    adv(1); cmpa_we_i = 0; chk("R8 shadow held", cmpa_o, 2);
    adv(2); chk("R8 before wrap", cmpa_o, 2);
    adv(1); chk("R8 wrap cnt", cnt_o, 0); chk("R8 loaded at wrap", cmpa_o, 5);
    adv(7); chk("R8 at top", cnt_o, 7); cmpa_we_i = 1; cmpa_i = 16'd3;
    adv(1); cmpa_we_i = 0; chk("R8 same-cycle write", cmpa_o, 3);

    // R7 update at TOP in dual slope
    setup(10, 2, 6);
    adv(2); cmpa_we_i = 1; cmpa_i = 16'd4;
    adv(1); cmpa_we_i = 0; chk("R7 held", cmpa_o, 2);
    adv(3); chk("R7 at top cnt", cnt_o, 6); chk("R7 held at top", cmpa_o, 2);
    adv(1); chk("R7 after top cnt", cnt_o, 5); chk("R7 loaded", cmpa_o, 4);

    // R8 update at BOTTOM in dual slope
    setup(8, 2, 6);
    adv(2); cmpa_we_i = 1; cmpa_i = 16'd4;
    adv(1); cmpa_we_i = 0;
    adv(9); chk("R8 bottom cnt", cnt_o, 0); chk("R8 held at bottom", cmpa_o, 2);
    adv(1); chk("R8 after bottom cnt", cnt_o, 1); chk("R8 loaded at bottom", cmpa_o, 4);

    // R6 immediate update
    setup(12, 2, 9);
    adv(3); cmpa_we_i = 1; cmpa_i = 16'd6;
    adv(1); cmpa_we_i = 0; chk("R6 immediate", cmpa_o, 6);

    // R10 clear, and set/clear collision
    setup(14, 2, 5);
    adv(6); chk("R9 first flag", ovf_o, 1); ovf_clr_i = 1;
    adv(1); ovf_clr_i = 0; chk("R10 cleared", ovf_o, 0);
    adv(4); chk("R10 at top cnt", cnt_o, 5); chk("R10 still clear", ovf_o, 0); ovf_clr_i = 1;
    adv(1); ovf_clr_i = 0; chk("R10 set wins", ovf_o, 1); ovf_clr_i = 1;
    adv(1); ovf_clr_i = 0; chk("R10 second clear", ovf_o, 0);

    // R2 enable low at TOP
    setup(14, 2, 5);
    adv(5); cnt_en_i = 0;
    adv(4); chk("R2 cnt held", cnt_o, 5); chk("R2 no flag", ovf_o, 0); chk("R2 pwm held", pwm_o, 0);
    cnt_en_i = 1;
    adv(1); chk("R2 resume cnt", cnt_o, 0); chk("R2 resume flag", ovf_o, 1); chk("R11 set at wrap", pwm_o, 1);

    // R13 reserved mode
    setup(14, 2, 5);
    adv(3); mode_we_i = 1; mode_i = 4'd13;
    adv(1); mode_we_i = 0; chk("R13 last step", cnt_o, 4);
    adv(10); chk("R13 held", cnt_o, 4); chk("R13 no flag", ovf_o, 0);

    // mode 0 full range
    setup(0, 16'h1234, 0);
    chk("R6 mode0 cmp", cmpa_o, 16'h1234);
    adv(1000); chk("R3 mode0 cnt", cnt_o, 1000);
    adv(64535); chk("R3 max cnt", cnt_o, 16'hFFFF); chk("R9 before max wrap", ovf_o, 0);
    adv(1); chk("R3 wrap", cnt_o, 0); chk("R9 max flag", ovf_o, 1);
    cmpa_we_i = 1; cmpa_i = 16'h0055;
    adv(1); cmpa_we_i = 0; chk("R6 mode0 write", cmpa_o, 16'h0055);

    // R1 reset after activity
    do_reset();
    chk("R1 cnt", cnt_o, 0); chk("R1 cmp", cmpa_o, 0);
    chk("R1 pwm", pwm_o, 0); chk("R1 ovf", ovf_o, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule